// File: doc/BRIEF.md
# Multi-Mode Converter Test Pattern Generator

This block feeds a converter transport layer with known sample data so that the link and the receiving logic can be checked without a real converter attached. On every enabled clock it produces one wide word made of sample slots. There is one slot for each frame in a clock, each converter and each sample. A two-bit mode input selects the slot contents at run time. The choices are a pseudo-random bit stream, an alternating checkerboard, a counting ramp, or all zeros.

Two small run-time inputs lower the number of active converters and samples below the built-in maximums. Slots outside the active set read as zero. Any change of mode or of the active counts makes every generator restart from its seed, so a receiver can resynchronise on a known first word. A build-time switch reverses the slot order across the whole word.

Top module: `conv_pattern_gen`

## Requirements
- R1: `mode` selects the slot contents: 0 = PRBS, 1 = checkerboard, 2 = ramp, 3 = every bit of `data_out` zero.
- R2: `data_out` is DIV*M_MAX*S_MAX*N bits wide. With REVERSE=0, slot k sits at bits [k*N +: N]. The index is k = (f*M_MAX + m)*S_MAX + s for frame f, converter m and sample s.
- R3: With REVERSE=1, the slot that would sit at position k is placed at position TOTAL-1-k, where TOTAL = DIV*M_MAX*S_MAX.
- R4: PRBS uses x^7+x^6+1 with a 7-bit state seeded to 7'h7F. Each bit is b = st[6]^st[5], and then st becomes {st[5:0], b}. Bits fill slot 0 from its MSB down, then slot 1, and so on, with all slots consuming bits. The state is never zero.
- R5: In checkerboard mode, a slot holds A when (k odd) XOR phase is 0 and holds ~A otherwise. A has bit i set exactly when i is odd (0xAA for N=8). The phase starts at 0 and inverts on every enabled clock.
- R6: In ramp mode, slot k holds (base + k) mod 2^N. The base starts at 0 and grows by TOTAL on every enabled clock, so each word continues from the previous word's last slot.
- R7: An `act_m` or `act_s` of 0 or above its maximum means the maximum. A slot whose converter m >= effective M, or whose sample s >= effective S, is zero.
- R8: On an enabled clock where the mode or an effective count differs from the previous enabled clock, the word produced equals the first word after reset for that setting. The generators continue from there.
- R9: `valid` is `en` registered one clock. While `en` is low, `data_out` and all generator state hold.
- R10: In reset, `valid` and `data_out` are 0 and the generators hold their seeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Produce a word on this clock |
| mode | input | 2 | Pattern select |
| act_m | input | $clog2(M_MAX+1) | Active converter count (0 = maximum) |
| act_s | input | $clog2(S_MAX+1) | Active samples per converter (0 = maximum) |
| data_out | output | DIV*M_MAX*S_MAX*N | Packed slot word |
| valid | output | 1 | `data_out` holds a fresh word |

## Verification
A restart caused by a configuration change and the zeroing of inactive slots can occur on the same clock. This happens when `act_m` or `act_s` changes in the middle of a ramp or PRBS run. The bench changes a count while a pattern is running. Its reference model then expects one word that is both reseeded and masked, and compares it to the natural-order instance and to a reversed-order instance. A pause on `en` is also placed between two words of one run, to show that the hold does not count as a configuration change.

// File: rtl/conv_pattern_gen.sv
module conv_pattern_gen #(
  parameter int DIV     = 2,
  parameter int M_MAX   = 2,
  parameter int S_MAX   = 2,
  parameter int N       = 8,
  parameter bit REVERSE = 1'b0,
  localparam int TOTAL  = DIV * M_MAX * S_MAX,
  localparam int W      = TOTAL * N,
  localparam int CW     = $clog2(M_MAX + 1),
  localparam int SW     = $clog2(S_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] act_m,
  input  logic [SW-1:0] act_s,
  output logic [W-1:0]  data_out,
  output logic          valid
);

  localparam logic [6:0] PRBS_SEED = 7'h7F;

  logic [1:0]    mode_q;
  logic [CW-1:0] m_q, eff_m;
  logic [SW-1:0] s_q, eff_s;
  logic [6:0]    prbs_q, prbs_src, prbs_next;
  logic          phase_q, phase_src;
  logic [N-1:0]  base_q, base_src;
  logic          restart;
  logic          started;
  logic [W-1:0]  prbs_w, chk_w, ramp_w, sel_w, mask_w, out_w;
  logic [N-1:0]  alt;

  assign eff_m = (act_m == '0 || act_m > CW'(M_MAX)) ? CW'(M_MAX) : act_m;
  assign eff_s = (act_s == '0 || act_s > SW'(S_MAX)) ? SW'(S_MAX) : act_s;

  assign restart   = (mode != mode_q) || (eff_m != m_q) || (eff_s != s_q);
  assign prbs_src  = restart ? PRBS_SEED : prbs_q;
  assign phase_src = restart ? 1'b0 : phase_q;
  assign base_src  = restart ? '0 : base_q;

  always_comb begin
    logic [6:0] st;
    logic       nb;
    st = prbs_src;
    prbs_w = '0;
    for (int k = 0; k < TOTAL; k++) begin
      for (int b = N - 1; b >= 0; b--) begin
        nb = st[6] ^ st[5];
        prbs_w[k*N + b] = nb;
        st = {st[5:0], nb};
      end
    end
    prbs_next = st;
  end

  always_comb begin
    for (int i = 0; i < N; i++) alt[i] = i[0];
  end

  genvar k;
  generate
    for (k = 0; k < TOTAL; k++) begin : g_slot
      localparam int SM = (k / S_MAX) % M_MAX;
      localparam int SS = k % S_MAX;
      localparam int POS = REVERSE ? (TOTAL - 1 - k) : k;
      logic on;
      assign chk_w[k*N +: N]  = ((k % 2 == 1) ^ phase_src) ? ~alt : alt;
      assign ramp_w[k*N +: N] = base_src + N'(k);
      assign on = (CW'(SM) < eff_m) && (SW'(SS) < eff_s);
      assign mask_w[k*N +: N] = on ? sel_w[k*N +: N] : '0;
      assign out_w[POS*N +: N] = mask_w[k*N +: N];
    end
  endgenerate

  always_comb begin
    case (mode)
      2'd0:    sel_w = prbs_w;
      2'd1:    sel_w = chk_w;
      2'd2:    sel_w = ramp_w;
      default: sel_w = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= 2'd0;
      m_q      <= CW'(M_MAX);
      s_q      <= SW'(S_MAX);
      prbs_q   <= PRBS_SEED;
      phase_q  <= 1'b0;
      base_q   <= '0;
      data_out <= '0;
      valid    <= 1'b0;
      started  <= 1'b0;
    end else begin
      valid   <= en;
      started <= 1'b1;
      if (en) begin
        mode_q   <= mode;
        m_q      <= eff_m;
        s_q      <= eff_s;
        prbs_q   <= prbs_next;
        phase_q  <= ~phase_src;
        base_q   <= base_src + N'(TOTAL);
        data_out <= out_w;
      end
    end
  end

  // R4: the shift register must never lock up in the all-zero state
  p_prbs_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    prbs_q != 7'd0);

  // R9: valid trails enable by exactly one clock
  p_valid_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (valid == $past(en)));

  // R9: a disabled clock leaves the output word untouched
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(data_out));

  // R1: the zero mode produces an all-zero word
  p_zero_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && mode_q == 2'd3) |-> (data_out == '0));

endmodule

// File: tb/conv_pattern_gen_bench.sv
module conv_pattern_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2, M_MAX = 2, S_MAX = 2, N = 8;
  localparam int TOTAL = DIV * M_MAX * S_MAX;
  localparam int W = TOTAL * N;
  localparam int CW = $clog2(M_MAX + 1);
  localparam int SW = $clog2(S_MAX + 1);

  logic clk = 0, rst_n = 0, en = 0;
  logic [1:0] mode = 0;
  logic [CW-1:0] act_m = 0;
  logic [SW-1:0] act_s = 0;
  logic [W-1:0] dout_n, dout_r;
  logic val_n, val_r;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_pattern_gen #(.DIV(DIV), .M_MAX(M_MAX), .S_MAX(S_MAX), .N(N), .REVERSE(1'b0)) u_conv_pattern_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .act_m(act_m), .act_s(act_s),
    .data_out(dout_n), .valid(val_n));

  conv_pattern_gen #(.DIV(DIV), .M_MAX(M_MAX), .S_MAX(S_MAX), .N(N), .REVERSE(1'b1)) u_conv_pattern_gen_rev (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .act_m(act_m), .act_s(act_s),
    .data_out(dout_r), .valid(val_r));

  // reference model state
  logic [1:0] md_q = 0;
  int mm_q = M_MAX, ms_q = S_MAX;
  logic [6:0] pr_q = 7'h7F;
  logic ph_q = 0;
  logic [N-1:0] bs_q = 0;

  logic [W-1:0] exp_q[$];
  string tag_q[$];

  function automatic logic [W-1:0] rev_word(input logic [W-1:0] w);
    logic [W-1:0] r;
    for (int i = 0; i < TOTAL; i++) r[(TOTAL-1-i)*N +: N] = w[i*N +: N];
    return r;
  endfunction

  function automatic int eff(input int v, input int mx);
    return (v == 0 || v > mx) ? mx : v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic step(input logic [1:0] md, input int am, input int as_);
    logic [W-1:0] w;
    logic [6:0] st;
    logic nb, ph;
    logic [N-1:0] bs, a;
    int em, es;
    bit rs;
    string tg;
    @(negedge clk);
    en = 1; mode = md; act_m = CW'(am); act_s = SW'(as_);
    em = eff(am, M_MAX); es = eff(as_, S_MAX);
    rs = (md != md_q) || (em != mm_q) || (es != ms_q);
    st = rs ? 7'h7F : pr_q;
    ph = rs ? 1'b0 : ph_q;
    bs = rs ? '0 : bs_q;
    for (int i = 0; i < N; i++) a[i] = (i % 2) == 1;
    w = '0;
    for (int k = 0; k < TOTAL; k++) begin
      logic [N-1:0] v;
      v = '0;
      for (int b = N - 1; b >= 0; b--) begin
        nb = st[6] ^ st[5];
        st = {st[5:0], nb};
        if (md == 2'd0) v[b] = nb;
      end
      if (md == 2'd1) v = (((k % 2) == 1) ^ ph) ? ~a : a;
      if (md == 2'd2) v = bs + N'(k);
      if (((k / S_MAX) % M_MAX) >= em || (k % S_MAX) >= es) v = '0;
      w[k*N +: N] = v;
    end
    case (md)
      2'd0: tg = "R4";
      2'd1: tg = "R5";
      2'd2: tg = "R6";
      default: tg = "R1";
    endcase
    if (em != M_MAX || es != S_MAX) tg = {tg, "/R7"};
    if (rs) tg = {tg, "/R8"};
    exp_q.push_back(w);
    tag_q.push_back(tg);
    md_q = md; mm_q = em; ms_q = es;
    pr_q = st; ph_q = ~ph; bs_q = bs + N'(TOTAL);
  endtask

  // monitor: compare both instances against the scoreboard
  always @(posedge clk) begin
    #1;
    if (rst_n && val_n) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected word", dout_n, '0);
      end else begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(dout_n == e, {t, "/R2"}, dout_n, e);
        check(val_r && dout_r == rev_word(e), {t, "/R3"}, dout_r, rev_word(e));
      end
    end
  end

  task automatic pause(input int cycles);
    logic [W-1:0] held;
    @(negedge clk);
    en = 0;
    @(negedge clk);
    held = dout_n;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check(!val_n, "R9 valid low while paused", W'(val_n), '0);
      check(dout_n == held, "R9 data held while paused", dout_n, held);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(dout_n == '0 && !val_n, "R10 reset", dout_n, '0);
    rst_n = 1;
    @(negedge clk);
    check(!val_n, "R10/R9 valid low while idle", W'(val_n), '0);
    for (int i = 0; i < 20; i++) step(2'd0, 0, 0);        // R4 full PRBS
    for (int i = 0; i < 6; i++)  step(2'd1, 0, 0);        // R5 checkerboard, R8 restart
    for (int i = 0; i < 40; i++) step(2'd2, 2, 2);        // R6 ramp with wrap
    for (int i = 0; i < 4; i++)  step(2'd2, 1, 2);        // R7 fewer converters + R8
    for (int i = 0; i < 4; i++)  step(2'd2, 3, 1);        // R7 over-max M, fewer samples
    for (int i = 0; i < 4; i++)  step(2'd0, 1, 1);        // R4 masked PRBS
    step(2'd2, 0, 0);
    step(2'd2, 0, 0);
    pause(4);                                             // R9 hold
    for (int i = 0; i < 3; i++)  step(2'd2, 0, 0);        // R9 resume continues ramp
    for (int i = 0; i < 3; i++)  step(2'd3, 0, 0);        // R1 zero mode
    for (int i = 0; i < 3; i++)  step(2'd0, 0, 0);        // R8 PRBS restarts from seed
    for (int i = 0; i < 3; i++)  step(2'd1, 1, 1);        // R5 masked checkerboard
    @(negedge clk);
    en = 0;
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9 all words delivered", W'(exp_q.size()), '0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule